// File: doc/BRIEF.md
# Deep standby wake-up controller

This block governs how a chip leaves its deepest low-power state. Software parks the chip there with a one-cycle request. While parked, the controller watches five wake pins and three internal wake events. The first pin cannot be masked. The other four each have an enable. Every pin has its own choice of rising or falling edge. The internal events are a slow-timer interrupt, a voltage-monitor interrupt and a bus suspend/resume interrupt. Each source latches a sticky flag, and software clears the flags by writing ones.

When any flag is set, the controller leaves standby. In that same cycle it requests supply power and oscillator start, and it asserts a chip-wide reset. It holds that reset for a programmable number of prescaled ticks, giving the oscillator time to settle. It then releases the reset, issues a one-cycle reset-exception pulse to the processor, and sets a status bit that records a wake by interrupt.

Three reset paths bypass the interrupt path:
- **Voltage-monitor reset:** the clock starts at once, and reset is held for as long as the monitor asserts it.
- **Power-on reset:** the oscillator is held off until the supply is good, then reset is held through the settle wait.
- **Reset pin:** the controller leaves standby at once, holds reset through the settle wait, and clears all flags and the status bit.

The analog oscillator and supply sit outside the block and are represented only by request and ready-level signals.

Top module: `deep_wake_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls: `stby_o`=0, `chip_rst_o`=0, `osc_en_o`=1, `pwr_req_o`=1, `rst_exc_o`=0, `wake_stat_o`=0 and `flags_o`=0.
- R2: A one-cycle `stby_req_i` seen in run state with `flags_o`=0 sets `stby_o` after the next clock edge, with `osc_en_o`, `pwr_req_o` and `chip_rst_o` all 0 while in standby. The request is ignored (`stby_o` stays 0) when any flag is set.
- R3: Flag bit i (i=0..4) follows wake pin i. Bit 0 is always enabled. Bit i>0 is enabled by `pin_en_i[i-1]`. `pin_rise_i[i]`=1 selects a rising edge and 0 selects a falling edge. A matching edge on an enabled pin, in standby, sets the flag on the third clock edge after the pin changes. A wrong edge, a disabled pin, or an edge outside standby sets nothing.
- R4: While in standby, a high `tmr_irq_i`, `lvd_irq_i` or `bus_irq_i` sets flag bit 5, 6 or 7 respectively on the next clock edge.
- R5: A 1 in bit i of `flag_clr_i` clears flag i on the next clock edge. Flags otherwise stay set.
- R6: The clock edge after any flag is set in standby clears `stby_o` and raises `pwr_req_o`, `osc_en_o` and `chip_rst_o` together.
- R7: After a settle wait begins, `chip_rst_o` stays high for exactly max(`wait_i`,1) × TICK_DIV clock cycles, with `wait_i` sampled when the wait begins.
- R8: `rst_exc_o` is high for exactly the one cycle in which `chip_rst_o` first reads 0 after a reset hold.
- R9: An exit caused by a flag sets `wake_stat_o` to 1 on the same edge that leaves standby.
- R10: A high `lvd_rst_i` drives `chip_rst_o`=1 and `osc_en_o`=1 from the next edge for as long as it stays high. The edge after it falls releases the reset with a `rst_exc_o` pulse and leaves `wake_stat_o` unchanged.
- R11: A high `por_i` gives `chip_rst_o`=1, `osc_en_o`=0, `flags_o`=0 and `wake_stat_o`=0 from the next edge. The edge after it falls sets `osc_en_o`=1 and starts the settle wait of R7.
- R12: A high `rst_pin_i` gives `chip_rst_o`=1, `osc_en_o`=1, `flags_o`=0 and `wake_stat_o`=0 from the next edge. The settle wait of R7 starts on the last edge at which it is high.
- R13: Power-on reset takes priority over voltage-monitor reset, which takes priority over the reset pin, which takes priority over flag wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| stby_req_i | input | 1 | One-cycle request to enter standby |
| pin_i | input | 5 | Wake pins; bit 0 is non-maskable |
| pin_en_i | input | 4 | Enables for wake pins 1..4 |
| pin_rise_i | input | 5 | Edge select per pin: 1 rising, 0 falling |
| tmr_irq_i | input | 1 | Slow-timer wake event |
| lvd_irq_i | input | 1 | Voltage-monitor wake event |
| bus_irq_i | input | 1 | Bus suspend/resume wake event |
| flag_clr_i | input | 8 | Write-one-to-clear strobes for the flags |
| wait_i | input | WAIT_W | Settle wait in ticks; 0 means one tick |
| lvd_rst_i | input | 1 | Voltage-monitor reset, high while the supply is low |
| por_i | input | 1 | Power-on reset, high until the supply has risen |
| rst_pin_i | input | 1 | External reset pin, active high |
| stby_o | output | 1 | Chip is in deep standby |
| pwr_req_o | output | 1 | Request for internal supply power |
| osc_en_o | output | 1 | Oscillator run request |
| chip_rst_o | output | 1 | Chip-wide reset |
| rst_exc_o | output | 1 | One-cycle reset-exception start pulse |
| wake_stat_o | output | 1 | Last exit was a wake by interrupt |
| flags_o | output | 8 | Sticky wake flags: bits 0..4 pins, 5 timer, 6 voltage monitor, 7 bus |

## Verification
The bench checks the settle length at both ends of the range: a wait of 0 and the full 6-bit value. A counter that treats 0 as zero ticks, or loses one prescaler cycle, releases reset a cycle early or late and misses the exact cycle count. Random pin toggles cover every mix of polarity and enable, so a swapped edge sense or a misrouted enable sets the wrong flag or wakes a parked chip. The bench raises the reset sources together and then drops them together. A design with the wrong priority either runs the oscillator during power-on reset or holds reset through a settle wait that a voltage-monitor exit must skip.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    localparam int N_PINS  = 5;
    localparam int N_FLAGS = 8;
    localparam int F_TMR   = 5;
    localparam int F_LVD   = 6;
    localparam int F_BUS   = 7;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_STBY,
        ST_SUPPLY,
        ST_SETTLE,
        ST_LVDHOLD
    } dwc_state_e;

    typedef struct packed {
        logic pwr;
        logic osc;
        logic rst;
    } dwc_ctl_t;

    // Supply, oscillator and chip-reset requests for each state.
    function automatic dwc_ctl_t ctl_of(dwc_state_e s);
        dwc_ctl_t c;
        case (s)
            ST_RUN:     c = '{pwr: 1'b1, osc: 1'b1, rst: 1'b0};
            ST_STBY:    c = '{pwr: 1'b0, osc: 1'b0, rst: 1'b0};
            ST_SUPPLY:  c = '{pwr: 1'b1, osc: 1'b0, rst: 1'b1};
            ST_SETTLE:  c = '{pwr: 1'b1, osc: 1'b1, rst: 1'b1};
            ST_LVDHOLD: c = '{pwr: 1'b1, osc: 1'b1, rst: 1'b1};
            default:    c = '{pwr: 1'b1, osc: 1'b1, rst: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dwc_pin_edge.sv
module dwc_pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Edge seen on the synchronised copy, in the selected direction.
    always_comb begin
        if (rise_sel_i) edge_o = s2_q & ~prev_q;
        else            edge_o = ~s2_q & prev_q;
    end
endmodule

// File: rtl/dwc_flag_bank.sv
module dwc_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wipe_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst || wipe_i) flags_q <= '0;
        else               flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/dwc_settle_timer.sv
module dwc_settle_timer #(
    parameter int WAIT_W   = 6,
    parameter int TICK_DIV = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              run_i,
    output logic              done_o
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [WAIT_W-1:0] tk_q;
    logic              last_pre;

    assign last_pre = (pre_q == PRE_LAST);
    assign done_o   = run_i && !load_i && last_pre && (tk_q == WAIT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            tk_q  <= WAIT_W'(1);
        end else if (load_i) begin
            pre_q <= '0;
            tk_q  <= (wait_i == '0) ? WAIT_W'(1) : wait_i;
        end else if (run_i) begin
            if (last_pre) begin
                pre_q <= '0;
                if (tk_q != WAIT_W'(1)) tk_q <= tk_q - WAIT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/deep_wake_ctrl.sv
module deep_wake_ctrl
    import dwc_pkg::*;
#(
    parameter int WAIT_W   = 6,
    parameter int TICK_DIV = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stby_req_i,
    input  logic [N_PINS-1:0]  pin_i,
    input  logic [N_PINS-2:0]  pin_en_i,
    input  logic [N_PINS-1:0]  pin_rise_i,
    input  logic               tmr_irq_i,
    input  logic               lvd_irq_i,
    input  logic               bus_irq_i,
    input  logic [N_FLAGS-1:0] flag_clr_i,
    input  logic [WAIT_W-1:0]  wait_i,
    input  logic               lvd_rst_i,
    input  logic               por_i,
    input  logic               rst_pin_i,
    output logic               stby_o,
    output logic               pwr_req_o,
    output logic               osc_en_o,
    output logic               chip_rst_o,
    output logic               rst_exc_o,
    output logic               wake_stat_o,
    output logic [N_FLAGS-1:0] flags_o
);
    dwc_state_e         state_q, state_d;
    dwc_ctl_t           ctl;
    logic [N_PINS-1:0]  pin_edge;
    logic [N_FLAGS-1:0] flag_set, flags;
    logic               in_stby, any_flag, wipe, load, done;
    logic               stat_q, stat_set, exc_q, exc_d;

    assign in_stby  = (state_q == ST_STBY);
    assign any_flag = |flags;

    // Per-pin synchroniser, edge select and enable.
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        logic en;
        if (g == 0) begin : g_nmi
            assign en = 1'b1;
        end else begin : g_mask
            assign en = pin_en_i[g-1];
        end
        dwc_pin_edge u_edge (
            .clk        (clk),
            .rst        (rst),
            .pin_i      (pin_i[g]),
            .rise_sel_i (pin_rise_i[g]),
            .edge_o     (pin_edge[g])
        );
        assign flag_set[g] = in_stby & en & pin_edge[g];
    end

    assign flag_set[F_TMR] = in_stby & tmr_irq_i;
    assign flag_set[F_LVD] = in_stby & lvd_irq_i;
    assign flag_set[F_BUS] = in_stby & bus_irq_i;

    // Power-on reset always wipes; the reset pin wipes unless a voltage-monitor reset outranks it.
    assign wipe = por_i | (rst_pin_i & ~lvd_rst_i);

    dwc_flag_bank #(.N(N_FLAGS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .wipe_i  (wipe),
        .set_i   (flag_set),
        .clr_i   (flag_clr_i),
        .flags_o (flags)
    );

    dwc_settle_timer #(.WAIT_W(WAIT_W), .TICK_DIV(TICK_DIV)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .wait_i (wait_i),
        .run_i  (state_q == ST_SETTLE),
        .done_o (done)
    );

    // Sequencer: power-on reset > voltage-monitor reset > reset pin > flag wake.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        stat_set = 1'b0;
        if (por_i) begin
            state_d = ST_SUPPLY;
        end else if (lvd_rst_i) begin
            state_d = ST_LVDHOLD;
        end else if (rst_pin_i) begin
            state_d = ST_SETTLE;
            load    = 1'b1;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (stby_req_i && !any_flag) state_d = ST_STBY;
                end
                ST_STBY: begin
                    if (any_flag) begin
                        state_d  = ST_SETTLE;
                        load     = 1'b1;
                        stat_set = 1'b1;
                    end
                end
                ST_SUPPLY: begin
                    state_d = ST_SETTLE;
                    load    = 1'b1;
                end
                ST_SETTLE: begin
                    if (done) state_d = ST_RUN;
                end
                ST_LVDHOLD: begin
                    state_d = ST_RUN;
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    assign exc_d = (state_d == ST_RUN) &&
                   ((state_q == ST_SETTLE) || (state_q == ST_LVDHOLD));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            exc_q   <= 1'b0;
            stat_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            exc_q   <= exc_d;
            if (wipe)          stat_q <= 1'b0;
            else if (stat_set) stat_q <= 1'b1;
        end
    end

    assign ctl         = ctl_of(state_q);
    assign stby_o      = in_stby;
    assign pwr_req_o   = ctl.pwr;
    assign osc_en_o    = ctl.osc;
    assign chip_rst_o  = ctl.rst;
    assign rst_exc_o   = exc_q;
    assign wake_stat_o = stat_q;
    assign flags_o     = flags;
endmodule

// File: rtl/dwc_checker.sv
module dwc_checker (
    input logic       clk,
    input logic       rst,
    input logic       lvd_rst_i,
    input logic       por_i,
    input logic       rst_pin_i,
    input logic       stby_o,
    input logic       pwr_req_o,
    input logic       osc_en_o,
    input logic       chip_rst_o,
    input logic       rst_exc_o,
    input logic       wake_stat_o,
    input logic [7:0] flags_o
);
    assert_entry_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        (!stby_o && (flags_o != 8'h00)) |=> !stby_o);

    assert_stby_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        stby_o |-> (!osc_en_o && !pwr_req_o && !chip_rst_o));

    assert_wake_together_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en_o) |-> (pwr_req_o && chip_rst_o));

    assert_release_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_rst_o) |-> rst_exc_o);

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        rst_exc_o |=> !rst_exc_o);

    assert_stat_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_stat_o) |-> $past(stby_o));

    assert_lvd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (lvd_rst_i && !por_i) |=> (chip_rst_o && osc_en_o));

    assert_por_hold_R11: assert property (@(posedge clk) disable iff (rst)
        por_i |=> (chip_rst_o && !osc_en_o && (flags_o == 8'h00) && !wake_stat_o));

    assert_pin_reset_R12: assert property (@(posedge clk) disable iff (rst)
        (rst_pin_i && !por_i && !lvd_rst_i) |=> (chip_rst_o && (flags_o == 8'h00) && !wake_stat_o));
endmodule

bind deep_wake_ctrl dwc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .lvd_rst_i   (lvd_rst_i),
    .por_i       (por_i),
    .rst_pin_i   (rst_pin_i),
    .stby_o      (stby_o),
    .pwr_req_o   (pwr_req_o),
    .osc_en_o    (osc_en_o),
    .chip_rst_o  (chip_rst_o),
    .rst_exc_o   (rst_exc_o),
    .wake_stat_o (wake_stat_o),
    .flags_o     (flags_o)
);

// File: tb/deep_wake_ctrl_tb.sv
module deep_wake_ctrl_tb;
    localparam int WAIT_W = 6;
    localparam int DIV    = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stby_req_i = 1'b0;
    logic [4:0] pin_i = '0;
    logic [3:0] pin_en_i = '0;
    logic [4:0] pin_rise_i = '0;
    logic       tmr_irq_i = 1'b0, lvd_irq_i = 1'b0, bus_irq_i = 1'b0;
    logic [7:0] flag_clr_i = '0;
    logic [WAIT_W-1:0] wait_i = '0;
    logic       lvd_rst_i = 1'b0, por_i = 1'b0, rst_pin_i = 1'b0;
    logic       stby_o, pwr_req_o, osc_en_o, chip_rst_o, rst_exc_o, wake_stat_o;
    logic [7:0] flags_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    deep_wake_ctrl #(.WAIT_W(WAIT_W), .TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .stby_req_i(stby_req_i), .pin_i(pin_i),
        .pin_en_i(pin_en_i), .pin_rise_i(pin_rise_i), .tmr_irq_i(tmr_irq_i),
        .lvd_irq_i(lvd_irq_i), .bus_irq_i(bus_irq_i), .flag_clr_i(flag_clr_i),
        .wait_i(wait_i), .lvd_rst_i(lvd_rst_i), .por_i(por_i), .rst_pin_i(rst_pin_i),
        .stby_o(stby_o), .pwr_req_o(pwr_req_o), .osc_en_o(osc_en_o),
        .chip_rst_o(chip_rst_o), .rst_exc_o(rst_exc_o), .wake_stat_o(wake_stat_o),
        .flags_o(flags_o)
    );

    function automatic int exp_settle(int w);
        return ((w == 0) ? 1 : w) * DIV;
    endfunction

    function automatic bit pin_hits(int idx, logic [3:0] en, logic [4:0] rise, logic lvl);
        return ((idx == 0) || en[idx-1]) && (rise[idx] == lvl);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Called at the negedge after a settle wait began; counts reset-hold cycles.
    task automatic run_settle(int exp_n, string req);
        int n = 0;
        while (chip_rst_o === 1'b1 && n < 20000) begin
            cyc(1);
            n++;
        end
        chk(n == exp_n, req, "reset hold cycles", n, exp_n);
        chk(rst_exc_o == 1'b1, "R8", "exception pulse at release", int'(rst_exc_o), 1);
        cyc(1);
        chk(rst_exc_o == 1'b0, "R8", "exception pulse width", int'(rst_exc_o), 0);
    endtask

    task automatic clear_flags();
        flag_clr_i = 8'hFF;
        cyc(1);
        flag_clr_i = 8'h00;
        chk(flags_o == 8'h00, "R5", "flags after write-one-clear", int'(flags_o), 0);
    endtask

    task automatic enter_stby();
        stby_req_i = 1'b1;
        cyc(1);
        stby_req_i = 1'b0;
        chk(stby_o == 1'b1, "R2", "standby entered", int'(stby_o), 1);
        chk({osc_en_o, pwr_req_o, chip_rst_o} == 3'b000, "R2", "standby outputs",
            int'({osc_en_o, pwr_req_o, chip_rst_o}), 0);
    endtask

    task automatic check_wake_edge();
        chk(stby_o == 1'b0, "R6", "standby left", int'(stby_o), 0);
        chk({pwr_req_o, osc_en_o, chip_rst_o} == 3'b111, "R6", "power/osc/reset together",
            int'({pwr_req_o, osc_en_o, chip_rst_o}), 7);
        chk(wake_stat_o == 1'b1, "R9", "wake status set", int'(wake_stat_o), 1);
    endtask

    task automatic pin_reset_exit(int w);
        rst_pin_i = 1'b1;
        cyc(1);
        rst_pin_i = 1'b0;
        chk(chip_rst_o == 1'b1 && osc_en_o == 1'b1, "R12", "reset pin holds reset",
            int'({chip_rst_o, osc_en_o}), 3);
        chk(flags_o == 8'h00 && wake_stat_o == 1'b0, "R12", "reset pin wipes flags/status",
            int'({wake_stat_o, flags_o}), 0);
        run_settle(exp_settle(w), "R12");
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));

        cyc(3);
        chk(stby_o == 0 && chip_rst_o == 0 && osc_en_o == 1 && pwr_req_o == 1,
            "R1", "outputs in reset", int'({stby_o, chip_rst_o, osc_en_o, pwr_req_o}), 3);
        rst = 1'b0;
        cyc(1);
        chk(flags_o == 0 && wake_stat_o == 0 && rst_exc_o == 0, "R1", "flags/status after reset",
            int'({rst_exc_o, wake_stat_o, flags_o}), 0);

        // R3: an edge outside standby sets nothing.
        pin_rise_i = 5'b00000;
        pin_i[0]   = 1'b1;
        cyc(2);
        pin_i[0]   = 1'b0;
        cyc(4);
        chk(flags_o == 0, "R3", "no flag outside standby", int'(flags_o), 0);

        // Non-maskable pin, rising edge, wait 0 gives one tick.
        pin_rise_i = 5'b00001;
        wait_i     = '0;
        enter_stby();
        pin_i[0] = 1'b1;
        cyc(3);
        chk(flags_o == 8'h01 && stby_o == 1, "R3", "NMI rising flag", int'(flags_o), 1);
        cyc(1);
        check_wake_edge();
        run_settle(exp_settle(0), "R7");

        // R2: a request while a flag is set is ignored.
        stby_req_i = 1'b1;
        cyc(1);
        stby_req_i = 1'b0;
        chk(stby_o == 1'b0, "R2", "request ignored with flag set", int'(stby_o), 0);
        cyc(1);
        chk(stby_o == 1'b0, "R2", "still running", int'(stby_o), 0);
        clear_flags();

        // R4: internal events, full wait.
        wait_i = 6'd63;
        for (int b = 5; b < 8; b++) begin
            enter_stby();
            tmr_irq_i = (b == 5);
            lvd_irq_i = (b == 6);
            bus_irq_i = (b == 7);
            cyc(1);
            tmr_irq_i = 1'b0;
            lvd_irq_i = 1'b0;
            bus_irq_i = 1'b0;
            chk(flags_o == (8'h01 << b) && stby_o == 1, "R4", "internal event flag",
                int'(flags_o), 1 << b);
            cyc(1);
            check_wake_edge();
            run_settle(exp_settle(63), "R7");
            clear_flags();
        end

        // R11: power-on reset.
        wait_i = 6'd2;
        por_i  = 1'b1;
        cyc(1);
        chk(chip_rst_o == 1 && osc_en_o == 0, "R11", "oscillator held off",
            int'({chip_rst_o, osc_en_o}), 2);
        chk(wake_stat_o == 0, "R11", "status wiped", int'(wake_stat_o), 0);
        cyc(2);
        por_i = 1'b0;
        cyc(1);
        chk(osc_en_o == 1 && chip_rst_o == 1, "R11", "oscillator starts after supply",
            int'({osc_en_o, chip_rst_o}), 3);
        run_settle(exp_settle(2), "R11");

        // R10: voltage-monitor reset from standby.
        enter_stby();
        lvd_rst_i = 1'b1;
        cyc(1);
        chk(chip_rst_o == 1 && osc_en_o == 1 && stby_o == 0, "R10", "clock at once, reset held",
            int'({chip_rst_o, osc_en_o, stby_o}), 6);
        cyc(2);
        chk(chip_rst_o == 1, "R10", "reset held while low supply", int'(chip_rst_o), 1);
        lvd_rst_i = 1'b0;
        cyc(1);
        chk(chip_rst_o == 0 && rst_exc_o == 1, "R10", "release after supply good",
            int'({chip_rst_o, rst_exc_o}), 1);
        chk(wake_stat_o == 0, "R10", "status not set", int'(wake_stat_o), 0);

        // R13: power-on beats voltage-monitor reset.
        por_i = 1'b1;
        lvd_rst_i = 1'b1;
        cyc(1);
        chk(osc_en_o == 0 && chip_rst_o == 1, "R13", "power-on wins", int'({osc_en_o, chip_rst_o}), 1);
        por_i = 1'b0;
        lvd_rst_i = 1'b0;
        cyc(1);
        run_settle(exp_settle(2), "R11");

        // R13: voltage-monitor reset beats the reset pin (no settle wait).
        enter_stby();
        lvd_rst_i = 1'b1;
        rst_pin_i = 1'b1;
        cyc(1);
        lvd_rst_i = 1'b0;
        rst_pin_i = 1'b0;
        cyc(1);
        chk(chip_rst_o == 0 && rst_exc_o == 1, "R13", "monitor path skips settle",
            int'({chip_rst_o, rst_exc_o}), 1);

        // Random pin sweep mixed with internal events.
        for (int it = 0; it < 30; it++) begin
            int kind;
            int w;
            w          = $urandom % 64;
            wait_i     = WAIT_W'(w);
            pin_en_i   = 4'($urandom);
            pin_rise_i = 5'($urandom);
            cyc(1);
            clear_flags();
            enter_stby();
            kind = $urandom % 4;
            if (kind < 3) begin
                int  idx;
                logic lvl;
                bit  hit;
                idx = $urandom % 5;
                lvl = ~pin_i[idx];
                hit = pin_hits(idx, pin_en_i, pin_rise_i, lvl);
                pin_i[idx] = lvl;
                cyc(3);
                chk(flags_o == (hit ? (8'h01 << idx) : 8'h00), "R3", "random pin flag",
                    int'(flags_o), hit ? (1 << idx) : 0);
                if (hit) begin
                    cyc(1);
                    check_wake_edge();
                    run_settle(exp_settle(w), "R7");
                end else begin
                    cyc(1);
                    chk(stby_o == 1, "R3", "no wake on ignored edge", int'(stby_o), 1);
                    pin_reset_exit(w);
                end
            end else begin
                pin_reset_exit(w);
            end
            cyc(4);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule